// File: doc/BRIEF.md
# Operand-Isolated Arithmetic/Logic Selector

This block is the operation selector at the top of a small computational unit. It accepts two N-bit operands and a 3-bit opcode. The opcode sends the operands to one of three sub-units: an external adder, an external multiplier, or a built-in logic section that computes OR, AND, XOR or the inverse of the first operand. The result of the chosen sub-unit is captured in an output register whose width is 2N.

Each sub-unit gets its operands through a bank of AND gates. The gates pass the operands only while that sub-unit is the one selected. Every other sub-unit sees constant zeros on its operand inputs, so its internal nodes do not toggle when the shared operand buses change. The adder and the multiplier sit outside this block. They connect through their operand output ports and their result input ports: an (N+1)-bit sum with carry, and a 2N-bit product.

Top module: `opsel_unit`

## Requirements
- R1: Opcode bit 2 low with bit 0 low selects addition: the registered result is the (N+1)-bit adder result, carry in bit N, with all higher bits zero.
- R2: Opcode bit 2 low with bit 0 high selects multiplication: the registered result is the full 2N-bit product from the multiplier port.
- R3: Opcode 100 gives the bitwise OR of A and B, zero-extended to 2N bits.
- R4: Opcode 101 gives the bitwise AND of A and B, zero-extended.
- R5: Opcode 110 gives the bitwise XOR of A and B, zero-extended.
- R6: Opcode 111 gives the bitwise inverse of A, zero-extended, and B has no effect.
- R7: The adder operand ports carry A and B in the same cycle while addition is selected, and both are all zeros under every other opcode.
- R8: The multiplier operand ports carry A and B in the same cycle while multiplication is selected, and both are all zeros under every other opcode.
- R9: Opcode bit 1 has no effect in the arithmetic section: 010 acts as 000 and 011 acts as 001.
- R10: The result register loads on a rising clock edge only while the input valid is high, and holds otherwise. The output valid is the input valid delayed by one cycle.
- R11: A synchronous active-low reset clears the result register and the output valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Opcode: bit 2 picks logic (1) or arithmetic (0) |
| add_a | output | WIDTH | Isolated first operand to the adder |
| add_b | output | WIDTH | Isolated second operand to the adder |
| add_sum | input | WIDTH+1 | Adder result with carry in the top bit |
| mul_a | output | WIDTH | Isolated first operand to the multiplier |
| mul_b | output | WIDTH | Isolated second operand to the multiplier |
| mul_prod | input | 2*WIDTH | Multiplier product |
| res_q | output | 2*WIDTH | Registered result |
| res_valid | output | 1 | Result register was loaded on the last edge |

## Verification
The bench builds the block with WIDTH = 8, which keeps the whole operand range small enough that table vectors can reach the extremes. With 0xFF + 0x01 the carry lands in bit 8, with 0xFF * 0xFF the product fills all 16 bits, and patterns such as 0xAA and 0xF0 exercise every logic function on both bit halves. The external adder and multiplier are modelled in the bench, so zero operands on the isolated ports can be observed directly for all eight opcodes, including the two where opcode bit 1 is set in the arithmetic section.

// File: rtl/opsel_pkg.sv
// Shared types for the operation selector.
// Assumes: the opcode is 3 bits, and bit 2 splits arithmetic from logic.
package opsel_pkg;

    // Logic-section function, taken from opcode bits [1:0].
    typedef enum logic [1:0] {
        LF_OR   = 2'b00,
        LF_AND  = 2'b01,
        LF_XOR  = 2'b10,
        LF_NOTA = 2'b11
    } logic_fn_e;

    // One enable per sub-unit; exactly one is set for any opcode.
    typedef struct packed {
        logic add;
        logic mul;
        logic lgc;
    } unit_en_t;

endpackage

// File: rtl/opsel_decode.sv
// Opcode decoder: turns the 3-bit opcode into one-hot sub-unit enables
// and a logic-function code.
// Assumes: purely combinational; bit 1 is ignored in the arithmetic section.
module opsel_decode
    import opsel_pkg::*;
(
    input  logic [2:0] sel,
    output unit_en_t   en,
    output logic_fn_e  fn
);

    // Decode the sub-unit enables and the logic function.
    always_comb begin
        en.lgc = sel[2];
        en.add = ~sel[2] & ~sel[0];
        en.mul = ~sel[2] &  sel[0];
        fn     = logic_fn_e'(sel[1:0]);
    end

endmodule

// File: rtl/opsel_iso_gate.sv
// Operand isolation bank: ANDs each operand bit with a sub-unit enable,
// so that a sub-unit which is not selected sees all zeros.
// Assumes: the enable is stable within a cycle; pure gating, no storage.
module opsel_iso_gate #(
    parameter int WIDTH = 8
) (
    input  logic             en,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] b_out
);

    // One AND gate per operand bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign a_out[i] = a_in[i] & en;
        assign b_out[i] = b_in[i] & en;
    end

endmodule

// File: rtl/opsel_logic.sv
// Logic section: OR, AND, XOR, or inverse of the first operand.
// Assumes: the operands arrive already isolated; combinational only.
module opsel_logic
    import opsel_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic_fn_e        fn,
    output logic [WIDTH-1:0] y
);

    // Pick the bitwise function.
    always_comb begin
        unique case (fn)
            LF_OR:   y = a | b;
            LF_AND:  y = a & b;
            LF_XOR:  y = a ^ b;
            LF_NOTA: y = ~a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/opsel_unit.sv
// Top-level operation selector with operand isolation.
// Steers the operands to the external adder, the external multiplier or
// the internal logic section. Sub-units that are not selected get zeros.
// Registers the selected result, zero-extended to 2*WIDTH.
// Assumes: the external adder and multiplier are combinational.
module opsel_unit
    import opsel_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    input  logic [2:0]         op_sel,
    output logic [WIDTH-1:0]   add_a,
    output logic [WIDTH-1:0]   add_b,
    input  logic [WIDTH:0]     add_sum,
    output logic [WIDTH-1:0]   mul_a,
    output logic [WIDTH-1:0]   mul_b,
    input  logic [2*WIDTH-1:0] mul_prod,
    output logic [2*WIDTH-1:0] res_q,
    output logic               res_valid
);

    localparam int RES_W = 2 * WIDTH;
    localparam int SUM_W = WIDTH + 1;
    localparam int PAD_W = RES_W - SUM_W;

    unit_en_t         en;
    logic_fn_e        fn;
    logic [WIDTH-1:0] lg_a;
    logic [WIDTH-1:0] lg_b;
    logic [WIDTH-1:0] lg_y;
    logic [RES_W-1:0] res_d;

    opsel_decode u_dec (
        .sel (op_sel),
        .en  (en),
        .fn  (fn)
    );

    opsel_iso_gate #(.WIDTH(WIDTH)) u_gate_add (
        .en    (en.add),
        .a_in  (op_a),
        .b_in  (op_b),
        .a_out (add_a),
        .b_out (add_b)
    );

    opsel_iso_gate #(.WIDTH(WIDTH)) u_gate_mul (
        .en    (en.mul),
        .a_in  (op_a),
        .b_in  (op_b),
        .a_out (mul_a),
        .b_out (mul_b)
    );

    opsel_iso_gate #(.WIDTH(WIDTH)) u_gate_lgc (
        .en    (en.lgc),
        .a_in  (op_a),
        .b_in  (op_b),
        .a_out (lg_a),
        .b_out (lg_b)
    );

    opsel_logic #(.WIDTH(WIDTH)) u_lgc (
        .a  (lg_a),
        .b  (lg_b),
        .fn (fn),
        .y  (lg_y)
    );

    // Select the active sub-unit's result, widened to RES_W.
    always_comb begin
        if (en.lgc)
            res_d = {{WIDTH{1'b0}}, lg_y};
        else if (en.mul)
            res_d = mul_prod;
        else
            res_d = {{PAD_W{1'b0}}, add_sum};
    end

    // Capture the result on valid input; reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= in_valid;
            if (in_valid)
                res_q <= res_d;
        end
    end

    // R7
    add_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[2] || op_sel[0]) |-> (add_a == '0 && add_b == '0));

    // R8
    mul_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel[2] || !op_sel[0]) |-> (mul_a == '0 && mul_b == '0));

    // R1
    add_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel[2] && !op_sel[0])
        |=> (res_q == {{PAD_W{1'b0}}, $past(add_sum)}));

    // R2
    mul_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel[2] && op_sel[0]) |=> (res_q == $past(mul_prod)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_q));

    // R10
    valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R11
    reset_chk: assert property (@(posedge clk)
        !rst_n |=> (res_q == '0 && !res_valid));

endmodule

// File: tb/sim_opsel_unit.sv
`timescale 1ns/1ps
module sim_opsel_unit;

    localparam int W  = 8;
    localparam int RW = 2 * W;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [2:0]    op_sel = 3'b000;
    logic [W-1:0]  add_a, add_b, mul_a, mul_b;
    logic [W:0]    add_sum;
    logic [RW-1:0] mul_prod;
    logic [RW-1:0] res_q;
    logic          res_valid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    // External adder and multiplier models.
    assign add_sum  = {1'b0, add_a} + {1'b0, add_b};
    assign mul_prod = {{W{1'b0}}, mul_a} * {{W{1'b0}}, mul_b};

    opsel_unit #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .add_a(add_a), .add_b(add_b), .add_sum(add_sum),
        .mul_a(mul_a), .mul_b(mul_b), .mul_prod(mul_prod),
        .res_q(res_q), .res_valid(res_valid)
    );

    // {opcode, A, B, expected result, requirement tag}
    typedef struct packed {
        logic [2:0]    sel;
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [RW-1:0] exp;
        logic [31:0]   tag;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{3'b000, 8'hFF, 8'h01, 16'h0100, "R1"},
        '{3'b000, 8'h80, 8'h80, 16'h0100, "R1"},
        '{3'b010, 8'h12, 8'h34, 16'h0046, "R9"},
        '{3'b001, 8'hFF, 8'hFF, 16'hFE01, "R2"},
        '{3'b001, 8'h00, 8'hFF, 16'h0000, "R2"},
        '{3'b011, 8'h0C, 8'h0A, 16'h0078, "R9"},
        '{3'b100, 8'hF0, 8'h0F, 16'h00FF, "R3"},
        '{3'b101, 8'hF0, 8'h3C, 16'h0030, "R4"},
        '{3'b110, 8'hAA, 8'hFF, 16'h0055, "R5"},
        '{3'b111, 8'h0F, 8'hFF, 16'h00F0, "R6"},
        '{3'b111, 8'h0F, 8'h00, 16'h00F0, "R6"},
        '{3'b000, 8'h7F, 8'h01, 16'h0080, "R1"}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Checks the isolated operand ports for the opcode currently driven.
    task automatic chk_ports();
        logic want_add, want_mul;
        want_add = !op_sel[2] && !op_sel[0];
        want_mul = !op_sel[2] &&  op_sel[0];
        chk("R7", {add_a, add_b}, want_add ? {op_a, op_b} : 16'h0000);
        chk("R8", {mul_a, mul_b}, want_mul ? {op_a, op_b} : 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", {res_valid, res_q}, 0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            op_sel   = VEC[i].sel;
            op_a     = VEC[i].a;
            op_b     = VEC[i].b;
            in_valid = 1'b1;
            #1 chk_ports();
            @(negedge clk);
            chk(string'(VEC[i].tag), res_q, VEC[i].exp);
            chk("R10", res_valid, 1);
        end

        // R10: valid low, result must hold and valid must drop.
        in_valid = 1'b0;
        op_sel   = 3'b001;
        op_a     = 8'h33;
        op_b     = 8'h44;
        #1 chk_ports();
        @(negedge clk);
        chk("R10", res_q, 16'h0080);
        chk("R10", res_valid, 0);

        // R6: B changes under NOT A must not alter the result.
        in_valid = 1'b1;
        op_sel   = 3'b111;
        op_a     = 8'h5A;
        op_b     = 8'hC3;
        #1 chk_ports();
        @(negedge clk);
        chk("R6", res_q, 16'h00A5);

        // R11: reset in the middle of operation.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", {res_valid, res_q}, 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R11", {res_valid, res_q}, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule